// File: doc/BRIEF.md
# Device-Keyed Translation Cache with Flush-on-Full

This block holds completed address translations so that a requester does not need a fresh page-table walk for a page it touched recently. Each entry is found by a key built from the requesting device's ID and the 4 KiB guest frame number. A lookup returns the translated address, the access permissions, the page mask and the owning domain in the same cycle. An update port installs a translation after a walk completes. Two invalidation inputs remove entries: one clears a single device's entries, the other clears the whole cache.

Translations that grant no access are never stored. The cache is fully associative. It does not pick a victim when it is full. When every slot is occupied and a new translation arrives, the whole cache is emptied and the new translation is written into it. A small occupancy machine tracks this with three states:

- `OCC_EMPTY`: no valid entries.
- `OCC_PARTIAL`: at least one slot is free and at least one is valid.
- `OCC_FULL`: every slot is valid.

The machine moves between these states through three named transitions:

- `T_FILL`: an accepted update takes a free slot, moving from EMPTY or PARTIAL to PARTIAL or FULL.
- `T_FLUSH_INSERT`: an accepted update arrives while the machine is in FULL; the machine moves to PARTIAL, holding one entry.
- `T_DRAIN`: an invalidation lowers the occupancy, moving to PARTIAL or EMPTY.

Top module: `xlat_cache`

## Requirements
- R1: A lookup is combinational. `lk_hit` is 1 in the same cycle when a valid entry's key equals `(lk_devid << DEVID_SHIFT) | (lk_gaddr >> 12)`. `lk_hit` is 0 whenever `lk_valid` is 0.
- R2: On a hit, the block returns the stored permission, domain and mask. `lk_addr` equals `(xaddr & ~mask) | (lk_gaddr & mask)`. A mask bit of 1 marks a page-offset bit taken from the request.
- R3: An update whose `upd_perm` is not 2'b00 (bit 0 grants read, bit 1 grants write) creates an entry. A lookup sees that entry from the cycle after the update.
- R4: An update with `upd_perm` == 2'b00 creates no entry and leaves every existing entry unchanged.
- R5: An accepted update whose key is already present replaces that entry's data. A replacement uses no additional slot.
- R6: An accepted update that arrives while all ENTRIES slots are valid first clears every entry and then stores the new one. After this, every older key misses.
- R7: `inv_dev_valid` clears every entry whose device ID equals `inv_devid`. Entries of other devices stay.
- R8: `inv_all` clears every entry.
- R9: When an invalidation and an update arrive in the same cycle, the invalidation wins and the update is discarded.
- R10: A lookup in the same cycle as an update to the same key returns the contents from before that update.
- R11: After reset, every lookup misses.
- R12: Slots freed by a device invalidation are reused. Entries that survived stay valid until the occupancy reaches ENTRIES again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_devid | input | DEVID_W | Device ID of the lookup |
| lk_gaddr | input | ADDR_W | Guest address of the lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_addr | output | ADDR_W | Translated address with the request offset merged in |
| lk_perm | output | 2 | Permissions of the hit entry |
| lk_domid | output | DOM_W | Domain of the hit entry |
| lk_mask | output | ADDR_W | Page mask of the hit entry |
| upd_valid | input | 1 | Update request |
| upd_devid | input | DEVID_W | Device ID of the update |
| upd_gaddr | input | ADDR_W | Guest address of the update |
| upd_perm | input | 2 | Permissions; 2'b00 means none |
| upd_xaddr | input | ADDR_W | Translated address |
| upd_mask | input | ADDR_W | Page mask (1 = offset bit) |
| upd_domid | input | DOM_W | Domain ID |
| inv_all | input | 1 | Clear every entry |
| inv_dev_valid | input | 1 | Clear the entries of one device |
| inv_devid | input | DEVID_W | Device whose entries are cleared |

## Verification
The bench builds the cache with ENTRIES = 4 and keeps the other parameters at their defaults. With only four slots, random traffic drawn from 24 keys passes through the `T_FLUSH_INSERT` transition many times. Replacements of an existing key, including replacements made while the cache is full, also occur often. Directed sequences fill the four slots exactly, make holes with a device invalidation and refill them, so the boundary between refilling a hole and flushing the cache is reached in a few dozen cycles.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
    localparam int PERM_W = 2;
    localparam logic [PERM_W-1:0] PERM_NONE = 2'b00;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;
endpackage

// File: rtl/xlat_cache_cam.sv
module xlat_cache_cam #(
    parameter int ENTRIES     = 8,
    parameter int KEY_W       = 44,
    parameter int DEVID_W     = 16,
    parameter int DEVID_SHIFT = 28
) (
    input  logic [ENTRIES-1:0][KEY_W-1:0] keys,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [KEY_W-1:0]              lk_key,
    input  logic [KEY_W-1:0]              up_key,
    input  logic [DEVID_W-1:0]            inv_devid,
    output logic [ENTRIES-1:0]            lk_match,
    output logic [ENTRIES-1:0]            up_match,
    output logic [ENTRIES-1:0]            dev_match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign lk_match[g]  = valid[g] && (keys[g] == lk_key);
        assign up_match[g]  = valid[g] && (keys[g] == up_key);
        assign dev_match[g] = valid[g] && (keys[g][DEVID_SHIFT +: DEVID_W] == inv_devid);
    end
endmodule

// File: rtl/xlat_cache_ctrl.sv
module xlat_cache_ctrl
    import xlat_cache_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_ok,
    input  logic               inv_all,
    input  logic               inv_dev,
    input  logic [ENTRIES-1:0] up_match,
    input  logic [ENTRIES-1:0] dev_match,
    output logic [ENTRIES-1:0] wr_sel,
    output logic [ENTRIES-1:0] valid_q,
    output occ_state_e         state_q
);
    localparam int CNT_W = $clog2(ENTRIES + 1);

    occ_state_e         state_d;
    logic [ENTRIES-1:0] valid_d;
    logic [CNT_W-1:0]   occ_d;

    function automatic logic [ENTRIES-1:0] lowest_free(input logic [ENTRIES-1:0] v);
        logic [ENTRIES-1:0] sel;
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!v[i]) sel = ENTRIES'(1) << i;
        end
        return sel;
    endfunction

    function automatic logic [CNT_W-1:0] occupancy(input logic [ENTRIES-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < ENTRIES; i++) n = n + CNT_W'(v[i]);
        return n;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            valid_q <= '0;
        end else begin
            state_q <= state_d;
            valid_q <= valid_d;
        end
    end

    // Next contents, write select and next state
    always_comb begin
        wr_sel  = '0;
        valid_d = valid_q;
        if (inv_all) begin
            valid_d = '0;
        end else if (inv_dev) begin
            valid_d = valid_q & ~dev_match;
        end else if (upd_ok) begin
            unique case (state_q)
                OCC_FULL: begin
                    // T_FLUSH_INSERT
                    wr_sel  = ENTRIES'(1);
                    valid_d = ENTRIES'(1);
                end
                OCC_EMPTY, OCC_PARTIAL: begin
                    // T_FILL or in-place replacement
                    if (|up_match) wr_sel = up_match;
                    else           wr_sel = lowest_free(valid_q);
                    valid_d = valid_q | wr_sel;
                end
                default: begin
                    wr_sel  = '0;
                    valid_d = valid_q;
                end
            endcase
        end
        occ_d = occupancy(valid_d);
        if (occ_d == '0)                      state_d = OCC_EMPTY;
        else if (occ_d == CNT_W'(ENTRIES))    state_d = OCC_FULL;
        else                                  state_d = OCC_PARTIAL;
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_cache_pkg::*;
#(
    parameter int ENTRIES     = 8,
    parameter int DEVID_W     = 16,
    parameter int ADDR_W      = 40,
    parameter int DOM_W       = 16,
    parameter int PAGE_SHIFT  = 12,
    parameter int DEVID_SHIFT = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [DEVID_W-1:0] lk_devid,
    input  logic [ADDR_W-1:0]  lk_gaddr,
    output logic               lk_hit,
    output logic [ADDR_W-1:0]  lk_addr,
    output logic [PERM_W-1:0]  lk_perm,
    output logic [DOM_W-1:0]   lk_domid,
    output logic [ADDR_W-1:0]  lk_mask,
    input  logic               upd_valid,
    input  logic [DEVID_W-1:0] upd_devid,
    input  logic [ADDR_W-1:0]  upd_gaddr,
    input  logic [PERM_W-1:0]  upd_perm,
    input  logic [ADDR_W-1:0]  upd_xaddr,
    input  logic [ADDR_W-1:0]  upd_mask,
    input  logic [DOM_W-1:0]   upd_domid,
    input  logic               inv_all,
    input  logic               inv_dev_valid,
    input  logic [DEVID_W-1:0] inv_devid
);
    localparam int KEY_W = DEVID_SHIFT + DEVID_W;

    function automatic logic [KEY_W-1:0] make_key(input logic [DEVID_W-1:0] dev,
                                                  input logic [ADDR_W-1:0]  ga);
        logic [KEY_W-1:0] k;
        k = KEY_W'(dev) << DEVID_SHIFT;
        k = k | KEY_W'(ga >> PAGE_SHIFT);
        return k;
    endfunction

    logic [ENTRIES-1:0][KEY_W-1:0]  key_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] xa_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] mask_q;
    logic [ENTRIES-1:0][PERM_W-1:0] perm_q;
    logic [ENTRIES-1:0][DOM_W-1:0]  dom_q;

    logic [ENTRIES-1:0] valid_q, wr_sel, lk_match, up_match, dev_match;
    occ_state_e         state_q;
    logic               upd_ok;

    assign upd_ok = upd_valid && (upd_perm != PERM_NONE);

    xlat_cache_cam #(
        .ENTRIES(ENTRIES), .KEY_W(KEY_W), .DEVID_W(DEVID_W), .DEVID_SHIFT(DEVID_SHIFT)
    ) u_cam (
        .keys      (key_q),
        .valid     (valid_q),
        .lk_key    (make_key(lk_devid, lk_gaddr)),
        .up_key    (make_key(upd_devid, upd_gaddr)),
        .inv_devid (inv_devid),
        .lk_match  (lk_match),
        .up_match  (up_match),
        .dev_match (dev_match)
    );

    xlat_cache_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_ok    (upd_ok),
        .inv_all   (inv_all),
        .inv_dev   (inv_dev_valid),
        .up_match  (up_match),
        .dev_match (dev_match),
        .wr_sel    (wr_sel),
        .valid_q   (valid_q),
        .state_q   (state_q)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (wr_sel[g]) begin
                key_q[g]  <= make_key(upd_devid, upd_gaddr);
                xa_q[g]   <= upd_xaddr;
                mask_q[g] <= upd_mask;
                perm_q[g] <= upd_perm;
                dom_q[g]  <= upd_domid;
            end
        end
    end

    // One-hot read mux for the lookup result
    always_comb begin
        logic [ADDR_W-1:0] xa_sel;
        xa_sel   = '0;
        lk_mask  = '0;
        lk_perm  = '0;
        lk_domid = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                xa_sel   = xa_sel   | xa_q[i];
                lk_mask  = lk_mask  | mask_q[i];
                lk_perm  = lk_perm  | perm_q[i];
                lk_domid = lk_domid | dom_q[i];
            end
        end
        lk_hit  = lk_valid && (|lk_match);
        lk_addr = (xa_sel & ~lk_mask) | (lk_gaddr & lk_mask);
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_cache_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic [PERM_W-1:0]  lk_perm,
    input logic               upd_valid,
    input logic [PERM_W-1:0]  upd_perm,
    input logic               inv_all,
    input logic               inv_dev_valid,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] valid_q,
    input occ_state_e         state_q
);
    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_valid);  // R1
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));  // R5
    AST_HIT_HAS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_perm != PERM_NONE));  // R4
    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_perm == PERM_NONE && !inv_all && !inv_dev_valid) |=> $stable(valid_q));  // R4
    AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_perm != PERM_NONE && !inv_all && !inv_dev_valid && (&valid_q))
        |=> ($countones(valid_q) == 1));  // R6
    AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));  // R8
    AST_INV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all || inv_dev_valid) |=> ((valid_q & ~$past(valid_q)) == '0));  // R9
    AST_STATE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL) == (&valid_q));  // R6
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_hit        (lk_hit),
    .lk_perm       (lk_perm),
    .upd_valid     (upd_valid),
    .upd_perm      (upd_perm),
    .inv_all       (inv_all),
    .inv_dev_valid (inv_dev_valid),
    .lk_match      (lk_match),
    .valid_q       (valid_q),
    .state_q       (state_q)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
    localparam int NE = 4;
    localparam int DW = 16;
    localparam int AW = 40;
    localparam int MW = 16;
    localparam int DSH = 28;
    localparam int KW = DSH + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [DW-1:0] lk_devid = '0;
    logic [AW-1:0] lk_gaddr = '0;
    logic          lk_hit;
    logic [AW-1:0] lk_addr;
    logic [1:0]    lk_perm;
    logic [MW-1:0] lk_domid;
    logic [AW-1:0] lk_mask;
    logic          upd_valid = 1'b0;
    logic [DW-1:0] upd_devid = '0;
    logic [AW-1:0] upd_gaddr = '0;
    logic [1:0]    upd_perm = '0;
    logic [AW-1:0] upd_xaddr = '0;
    logic [AW-1:0] upd_mask = '0;
    logic [MW-1:0] upd_domid = '0;
    logic          inv_all = 1'b0;
    logic          inv_dev_valid = 1'b0;
    logic [DW-1:0] inv_devid = '0;

    always #10 clk = ~clk;

    xlat_cache #(.ENTRIES(NE), .DEVID_W(DW), .ADDR_W(AW), .DOM_W(MW),
                 .PAGE_SHIFT(12), .DEVID_SHIFT(DSH)) u0 (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference contents
    bit            m_v   [NE];
    logic [KW-1:0] m_key [NE];
    logic [DW-1:0] m_dev [NE];
    logic [AW-1:0] m_xa  [NE];
    logic [AW-1:0] m_mask[NE];
    logic [1:0]    m_perm[NE];
    logic [MW-1:0] m_dom [NE];

    function automatic logic [KW-1:0] ref_key(input logic [DW-1:0] d, input logic [AW-1:0] a);
        return (KW'(d) << DSH) | KW'(a >> 12);
    endfunction

    function automatic int ref_find(input logic [KW-1:0] k);
        for (int i = 0; i < NE; i++) if (m_v[i] && m_key[i] == k) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ref_apply();
        int idx, cnt;
        if (inv_all) begin
            for (int i = 0; i < NE; i++) m_v[i] = 0;
        end else if (inv_dev_valid) begin
            for (int i = 0; i < NE; i++) if (m_dev[i] == inv_devid) m_v[i] = 0;
        end else if (upd_valid && upd_perm != 2'b00) begin
            cnt = 0;
            for (int i = 0; i < NE; i++) cnt += int'(m_v[i]);
            if (cnt == NE) for (int i = 0; i < NE; i++) m_v[i] = 0;
            idx = ref_find(ref_key(upd_devid, upd_gaddr));
            if (idx < 0) begin
                for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) idx = i;
            end
            m_v[idx] = 1; m_key[idx] = ref_key(upd_devid, upd_gaddr);
            m_dev[idx] = upd_devid; m_xa[idx] = upd_xaddr; m_mask[idx] = upd_mask;
            m_perm[idx] = upd_perm; m_dom[idx] = upd_domid;
        end
    endtask

    // Inputs are already driven (just after a falling edge)
    task automatic tick(input string tag);
        int idx;
        logic [AW-1:0] ea;
        #2;
        if (!lk_valid) begin
            chk(lk_hit == 1'b0, {tag, "/R1 idle"}, AW'(lk_hit), '0);
        end else begin
            idx = ref_find(ref_key(lk_devid, lk_gaddr));
            chk(lk_hit == (idx >= 0), {tag, " hit"}, AW'(lk_hit), AW'(idx >= 0));
            if (idx >= 0 && lk_hit) begin
                ea = (m_xa[idx] & ~m_mask[idx]) | (lk_gaddr & m_mask[idx]);
                chk(lk_addr == ea, {tag, "/R2 addr"}, lk_addr, ea);
                chk(lk_perm == m_perm[idx], {tag, "/R2 perm"}, AW'(lk_perm), AW'(m_perm[idx]));
                chk(lk_domid == m_dom[idx], {tag, "/R2 dom"}, AW'(lk_domid), AW'(m_dom[idx]));
                chk(lk_mask == m_mask[idx], {tag, "/R2 mask"}, lk_mask, m_mask[idx]);
            end
        end
        ref_apply();
        @(negedge clk);
    endtask

    task automatic idle_in();
        lk_valid = 0; upd_valid = 0; inv_all = 0; inv_dev_valid = 0; upd_perm = 2'b00;
    endtask

    task automatic put(input logic [DW-1:0] d, input logic [27:0] gfn, input logic [1:0] p,
                       input logic [AW-1:0] xa, input logic [MW-1:0] dom);
        upd_valid = 1; upd_devid = d; upd_gaddr = {gfn, 12'h0}; upd_perm = p;
        upd_xaddr = xa; upd_mask = 40'hFFF; upd_domid = dom;
    endtask

    task automatic look(input logic [DW-1:0] d, input logic [27:0] gfn, input logic [11:0] off, input string tag);
        idle_in();
        lk_valid = 1; lk_devid = d; lk_gaddr = {gfn, off};
        tick(tag);
    endtask

    task automatic ins(input logic [DW-1:0] d, input logic [27:0] gfn, input logic [1:0] p, input logic [MW-1:0] dom, input string tag);
        idle_in();
        put(d, gfn, p, {gfn + 28'h100, 12'h0} ^ 40'hAB_0000_0000, dom);
        tick(tag);
    endtask

    // Expected hit bits are also stated directly from the requirements
    task automatic expect_hit(input logic [DW-1:0] d, input logic [27:0] gfn, input bit exp, input string tag);
        idle_in();
        lk_valid = 1; lk_devid = d; lk_gaddr = {gfn, 12'h5A4};
        #2;
        chk(lk_hit == exp, tag, AW'(lk_hit), AW'(exp));
        ref_apply();
        @(negedge clk);
    endtask

    initial begin
        int r;
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        r = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11: empty after reset
        expect_hit(16'h1, 28'h10, 0, "R11");
        // R10: lookup during update of the same key sees old contents
        idle_in();
        lk_valid = 1; lk_devid = 16'h1; lk_gaddr = {28'h10, 12'h123};
        put(16'h1, 28'h10, 2'b11, 40'h77_7777_7000, 16'h42);
        tick("R10");
        chk(1'b1, "R10", '0, '0);
        expect_hit(16'h1, 28'h10, 1, "R3");
        look(16'h1, 28'h10, 12'hFED, "R2");
        // R4: no-permission update ignored
        ins(16'h2, 28'h20, 2'b00, 16'h9, "R4");
        expect_hit(16'h2, 28'h20, 0, "R4");
        expect_hit(16'h1, 28'h10, 1, "R4");
        // R5: replace in place, then fill remaining slots without flush
        ins(16'h1, 28'h10, 2'b01, 16'h55, "R5");
        look(16'h1, 28'h10, 12'h001, "R5");
        ins(16'h1, 28'h11, 2'b10, 16'h1, "R5");
        ins(16'h2, 28'h12, 2'b01, 16'h2, "R5");
        ins(16'h3, 28'h13, 2'b11, 16'h3, "R5");
        expect_hit(16'h1, 28'h10, 1, "R5");
        expect_hit(16'h3, 28'h13, 1, "R5");
        // R6: fifth distinct key flushes
        ins(16'h3, 28'h14, 2'b01, 16'h4, "R6");
        expect_hit(16'h1, 28'h10, 0, "R6");
        expect_hit(16'h2, 28'h12, 0, "R6");
        expect_hit(16'h3, 28'h14, 1, "R6");
        // R7: device invalidation
        ins(16'h1, 28'h30, 2'b01, 16'h6, "R7");
        ins(16'h2, 28'h31, 2'b01, 16'h7, "R7");
        idle_in(); inv_dev_valid = 1; inv_devid = 16'h1; tick("R7");
        expect_hit(16'h1, 28'h30, 0, "R7");
        expect_hit(16'h2, 28'h31, 1, "R7");
        expect_hit(16'h3, 28'h14, 1, "R7");
        // R12: holes refilled before a flush happens
        ins(16'h4, 28'h40, 2'b11, 16'h8, "R12");
        ins(16'h4, 28'h41, 2'b11, 16'h8, "R12");
        expect_hit(16'h2, 28'h31, 1, "R12");
        expect_hit(16'h3, 28'h14, 1, "R12");
        // R9: invalidation beats a same-cycle update
        idle_in(); inv_dev_valid = 1; inv_devid = 16'h4;
        put(16'h5, 28'h50, 2'b01, 40'h1000, 16'h1); tick("R9");
        expect_hit(16'h5, 28'h50, 0, "R9");
        idle_in(); inv_all = 1; put(16'h6, 28'h60, 2'b01, 40'h2000, 16'h1); tick("R9");
        expect_hit(16'h6, 28'h60, 0, "R9");
        // R8: invalidate all
        ins(16'h2, 28'h70, 2'b01, 16'h1, "R8");
        idle_in(); inv_all = 1; tick("R8");
        expect_hit(16'h2, 28'h70, 0, "R8");

        // Random traffic over a small key pool
        for (int c = 0; c < 4000; c++) begin
            int op;
            idle_in();
            lk_valid = ($urandom % 8) != 0;
            lk_devid = DW'($urandom % 4);
            lk_gaddr = {28'($urandom % 6), 12'($urandom)};
            op = $urandom % 100;
            if (op < 55) begin
                upd_valid = 1;
                upd_devid = DW'($urandom % 4);
                upd_gaddr = {28'($urandom % 6), 12'($urandom)};
                upd_perm  = 2'($urandom);
                upd_xaddr = {8'($urandom), 32'($urandom)};
                upd_mask  = ($urandom % 2) ? 40'hFFF : 40'h1F_FFFF;
                upd_domid = MW'($urandom);
            end
            if (op >= 90 && op < 96) begin inv_dev_valid = 1; inv_devid = DW'($urandom % 4); end
            if (op >= 96) inv_all = 1;
            tick("R1 rnd");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule